// File: doc/BRIEF.md
# Parameterised Recursive Convolutional Encoder

This block is a streaming convolutional encoder. Each accepted input beat carries one information bit. For that bit the block produces one parity bit per tap polynomial, and the parity bits are packed into a single output word. The tap polynomials, the constraint length K, the number of parity outputs and an optional feedback polynomial are all fixed by parameters. A feedback value of zero gives a plain feed-forward code. Any other value gives a recursive code. The encoder register holds K-1 bits, so the code has 2^(K-1) trellis states.

Both sides use a valid/ready stream handshake. A last flag marks the final bit of a block. The flag is passed to the output beat of that bit, and the encoder register is cleared after that bit, so every block starts from the all-zero state. The block is meant to generate reference streams and stimulus for a soft-decision decoder. Only the information bits are encoded: the block adds no tail bits, punctures nothing, interleaves nothing and does no soft-value mapping.

A single register stage holds each output beat. A two-state machine tracks that stage. In ST_EMPTY the stage holds nothing. The transition take_first moves the machine to ST_LOADED when a beat is accepted. In ST_LOADED the stage holds a beat. The transition drain_idle returns the machine to ST_EMPTY when the beat leaves and no new beat enters. The machine stays in ST_LOADED through a stall, and through a refill where one beat leaves while the next enters.

Top module: `conv_stream_enc`

## Requirements
- R1: While rst_n is sampled low at a rising clk edge, the block resets. After reset, out_valid is 0, in_ready is 1 and the encoder register is all zero.
- R2: The parity for output bit j is the XOR of the window bits selected by POLYS[j]. Bit i of POLYS[j] is the coefficient of delay i: bit 0 (the constant term) selects the current register input, and bit K-1 (the most significant bit) selects the register input from K-1 beats earlier.
- R3: When FB is nonzero, the bit that enters the register is the input bit XOR the parity of the stored bits selected by FB bits 1 to K-1 (bit i selects the bit entered i beats earlier). FB bit 0 is not used. When FB is 0, the input bit enters the register unchanged.
- R4: out_par is N_PAR bits wide, with parity j in bit j. Any N_PAR of 2 or more is accepted, giving rate 1/N_PAR.
- R5: After a beat with in_last set is accepted, the register is all zero. The next block is therefore encoded from state 0.
- R6: out_last equals the in_last value of the input beat that produced the output beat.
- R7: in_ready is 1 exactly when the output stage is empty or out_ready is 1. Every accepted beat produces exactly one output beat, in order, and no output beat appears without an accepted input.
- R8: A beat accepted at one rising edge appears on the outputs, with out_valid set, right after that edge.
- R9: While out_valid is 1 and out_ready is 0, the output beat is held: out_valid stays 1 and out_par and out_last do not change.
- R10: Cycles with no accepted beat leave the encoder register unchanged. A beat that follows an idle gap continues the same block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input beat is present |
| in_ready | output | 1 | Block can take an input beat this cycle |
| in_bit | input | 1 | Information bit |
| in_last | input | 1 | Marks the final bit of a block |
| out_valid | output | 1 | Output beat is present |
| out_ready | input | 1 | Downstream takes the output beat |
| out_par | output | N_PAR | Parity word, parity j in bit j |
| out_last | output | 1 | Marks the output beat of the final bit of a block |

## Verification
Four encoder instances share one input stream: the two K=7 codes at rates 1/2 and 1/3, a K=5 feed-forward code, and a K=5 recursive code at rate 1/4. The parity words from the feed-forward instances separate tap-order and bit-placement errors, and the recursive instance exposes any fault in the feedback path. First, every 8-bit sequence is sent as its own block at full rate, which shows whether each block restarts from state 0. Next, random bits with random block ends, input gaps and output stalls show whether idle cycles keep the state and whether a held beat stays stable. A final long stall checks that no beat is lost.

// File: rtl/conv_enc_pkg.sv
package conv_enc_pkg;

    // Occupancy of the single output register stage
    typedef enum logic [0:0] {
        ST_EMPTY  = 1'b0,
        ST_LOADED = 1'b1
    } ostate_e;

    // Smallest constraint length the register slicing supports
    localparam int unsigned MIN_CONSTRAINT = 3;

endpackage

// File: rtl/conv_enc_feedback.sv
// Picks the bit that enters the encoder register: feed-forward or recursive.
module conv_enc_feedback #(
    parameter int unsigned SW = 6,
    parameter int unsigned FB = 0
) (
    input  logic [SW-1:0] state,
    input  logic          u,
    output logic          a
);
    // FB bit i (i >= 1) selects state bit i-1; the constant term is dropped
    localparam logic [SW-1:0] FB_TAPS = SW'(FB >> 1);

    generate
        if (FB == 0) begin : g_forward
            assign a = u;
        end else begin : g_recursive
            assign a = u ^ (^(state & FB_TAPS));
        end
    endgenerate
endmodule

// File: rtl/conv_enc_parity.sv
// One XOR tree per polynomial over the K-bit window.
module conv_enc_parity #(
    parameter int unsigned                   K     = 7,
    parameter int unsigned                   N_PAR = 2,
    parameter logic [N_PAR-1:0][31:0]        POLYS = {32'd121, 32'd91}
) (
    input  logic [K-1:0]     win,
    output logic [N_PAR-1:0] par
);
    generate
        for (genvar j = 0; j < N_PAR; j++) begin : g_tap
            localparam logic [K-1:0] MASK = POLYS[j][K-1:0];
            assign par[j] = ^(win & MASK);
        end
    endgenerate
endmodule

// File: rtl/conv_enc_core.sv
// Encoder register with block restart; produces the parity word for the current bit.
module conv_enc_core #(
    parameter int unsigned            K     = 7,
    parameter int unsigned            N_PAR = 2,
    parameter int unsigned            FB    = 0,
    parameter logic [N_PAR-1:0][31:0] POLYS = {32'd121, 32'd91}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic             blk_end,
    input  logic             u,
    output logic [N_PAR-1:0] par
);
    localparam int unsigned SW = K - 1;

    logic [SW-1:0] st_q;
    logic          a;
    logic [K-1:0]  win;

    conv_enc_feedback #(.SW(SW), .FB(FB)) u_fb (
        .state (st_q),
        .u     (u),
        .a     (a)
    );

    // Window bit 0 is the newest register input, bit i is i beats older
    assign win = {st_q, a};

    conv_enc_parity #(.K(K), .N_PAR(N_PAR), .POLYS(POLYS)) u_par (
        .win (win),
        .par (par)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else if (take) begin
            st_q <= blk_end ? '0 : win[SW-1:0];
        end
    end

    // R5: a block end leaves the register cleared
    p_clear_after_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (take && blk_end) |=> (st_q == '0));

    // R10: no accepted beat, no register change
    p_idle_keeps_state_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(st_q));
endmodule

// File: rtl/conv_enc_ostage.sv
// Output register stage and its two-state occupancy machine.
module conv_enc_ostage
    import conv_enc_pkg::*;
#(
    parameter int unsigned N_PAR = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic             in_last,
    input  logic [N_PAR-1:0] par_in,
    input  logic             out_ready,
    output logic             in_ready,
    output logic             take_o,
    output logic             out_valid,
    output logic [N_PAR-1:0] out_par,
    output logic             out_last
);
    ostate_e          st_q;
    ostate_e          st_d;
    logic             drain;
    logic [N_PAR-1:0] par_q;
    logic             last_q;

    assign in_ready = (st_q == ST_EMPTY) || out_ready;
    assign take_o   = in_valid && in_ready;
    assign drain    = (st_q == ST_LOADED) && out_ready;

    // Transitions: take_first (EMPTY->LOADED), drain_idle (LOADED->EMPTY)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_EMPTY:  if (take_o)            st_d = ST_LOADED;
            ST_LOADED: if (drain && !take_o)  st_d = ST_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_EMPTY;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_q  <= '0;
            last_q <= 1'b0;
        end else if (take_o) begin
            par_q  <= par_in;
            last_q <= in_last;
        end
    end

    assign out_valid = (st_q == ST_LOADED);
    assign out_par   = par_q;
    assign out_last  = last_q;

    // R8: an accepted beat is presented right after its edge
    p_take_presents_r8: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> out_valid);

    // R9: a stalled beat is held unchanged
    p_hold_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_par) && $stable(out_last)));

    // R7: a beat that leaves with no refill empties the stage
    p_drain_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_ready && !in_valid) |=> !out_valid);
endmodule

// File: rtl/conv_stream_enc.sv
// Streaming convolutional encoder, feed-forward or recursive by parameter.
module conv_stream_enc #(
    parameter int unsigned            K     = 7,
    parameter int unsigned            N_PAR = 2,
    parameter int unsigned            FB    = 0,
    parameter logic [N_PAR-1:0][31:0] POLYS = {32'd121, 32'd91}
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic             in_bit,
    input  logic             in_last,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [N_PAR-1:0] out_par,
    output logic             out_last
);
    logic             take;
    logic [N_PAR-1:0] par_now;

    conv_enc_core #(.K(K), .N_PAR(N_PAR), .FB(FB), .POLYS(POLYS)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .take    (take),
        .blk_end (in_last),
        .u       (in_bit),
        .par     (par_now)
    );

    conv_enc_ostage #(.N_PAR(N_PAR)) u_ostage (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_last   (in_last),
        .par_in    (par_now),
        .out_ready (out_ready),
        .in_ready  (in_ready),
        .take_o    (take),
        .out_valid (out_valid),
        .out_par   (out_par),
        .out_last  (out_last)
    );
endmodule

// File: tb/conv_stream_enc_bench.sv
module conv_stream_enc_bench;
    localparam int CLK_PERIOD = 10;

    // Per-instance configuration: K, rate denominator, feedback, polynomials
    localparam int CK  [4]    = '{7, 7, 5, 5};
    localparam int CN  [4]    = '{2, 3, 2, 4};
    localparam int CFB [4]    = '{0, 0, 0, 19};
    localparam int CP  [4][4] = '{'{91, 121, 0, 0}, '{91, 121, 117, 0},
                                  '{27, 19, 0, 0},  '{27, 29, 23, 31}};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_bit = 1'b0, in_last = 1'b0, out_ready = 1'b0;
    logic rdy0, rdy1, rdy2, rdy3;
    logic ov0, ov1, ov2, ov3;
    logic ol0, ol1, ol2, ol3;
    logic [1:0] d0;
    logic [2:0] d1;
    logic [1:0] d2;
    logic [3:0] d3;

    always #(CLK_PERIOD / 2) clk = ~clk;

    conv_stream_enc #(.K(7), .N_PAR(2), .FB(0), .POLYS({32'd121, 32'd91})) u_conv_stream_enc (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy0), .in_bit(in_bit),
        .in_last(in_last), .out_valid(ov0), .out_ready(out_ready), .out_par(d0), .out_last(ol0));
    conv_stream_enc #(.K(7), .N_PAR(3), .FB(0), .POLYS({32'd117, 32'd121, 32'd91})) u_conv_stream_enc_r3 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy1), .in_bit(in_bit),
        .in_last(in_last), .out_valid(ov1), .out_ready(out_ready), .out_par(d1), .out_last(ol1));
    conv_stream_enc #(.K(5), .N_PAR(2), .FB(0), .POLYS({32'd19, 32'd27})) u_conv_stream_enc_k5 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy2), .in_bit(in_bit),
        .in_last(in_last), .out_valid(ov2), .out_ready(out_ready), .out_par(d2), .out_last(ol2));
    conv_stream_enc #(.K(5), .N_PAR(4), .FB(19), .POLYS({32'd31, 32'd23, 32'd29, 32'd27})) u_conv_stream_enc_rec (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(rdy3), .in_bit(in_bit),
        .in_last(in_last), .out_valid(ov3), .out_ready(out_ready), .out_par(d3), .out_last(ol3));

    int nchk = 0;
    int nfail = 0;
    int q0[$], q1[$], q2[$], q3[$];
    int mst [4] = '{0, 0, 0, 0};
    bit first_blk = 1'b1;
    bit prev_acc = 1'b0;
    bit prev_stall = 1'b0;
    int prev_beat = 0;
    bit sv [4];
    bit sr [4];
    bit sl [4];
    int sd [4];

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Encoder model built from the requirement text (R2, R3, R4)
    function automatic int ref_word(input int idx, input bit u, inout int st);
        int a, w, res;
        a = int'(u) ^ ($countones(st & (CFB[idx] >> 1)) & 1);
        w = (st << 1) | a;
        res = 0;
        for (int j = 0; j < CN[idx]; j++)
            res = res | (($countones(w & CP[idx][j]) & 1) << j);
        st = w & ((1 << (CK[idx] - 1)) - 1);
        return res;
    endfunction

    function automatic void q_push(input int idx, input int v);
        case (idx)
            0: q0.push_back(v);
            1: q1.push_back(v);
            2: q2.push_back(v);
            default: q3.push_back(v);
        endcase
    endfunction

    function automatic int q_pop(input int idx);
        int v;
        v = -1;
        case (idx)
            0: if (q0.size() > 0) v = q0.pop_front();
            1: if (q1.size() > 0) v = q1.pop_front();
            2: if (q2.size() > 0) v = q2.pop_front();
            default: if (q3.size() > 0) v = q3.pop_front();
        endcase
        return v;
    endfunction

    task automatic sample_outputs();
        sv[0] = ov0; sv[1] = ov1; sv[2] = ov2; sv[3] = ov3;
        sr[0] = rdy0; sr[1] = rdy1; sr[2] = rdy2; sr[3] = rdy3;
        sl[0] = ol0; sl[1] = ol1; sl[2] = ol2; sl[3] = ol3;
        sd[0] = int'(d0); sd[1] = int'(d1); sd[2] = int'(d2); sd[3] = int'(d3);
    endtask

    // One clock: drive for the next edge, then account for that edge's transfers
    task automatic cycle(input bit v, input bit d, input bit l, input bit r, output bit acc);
        bit gap;
        @(negedge clk);
        in_valid = v; in_bit = d; in_last = l; out_ready = r;
        #1;
        sample_outputs();
        if (prev_acc) chk(sv[0], "R8 beat not presented after acceptance", int'(sv[0]), 1);
        if (prev_stall) chk(sv[0] && (sd[0] | (int'(sl[0]) << 8)) == prev_beat,
                            "R9 stalled beat changed", sd[0] | (int'(sl[0]) << 8), prev_beat);
        for (int i = 0; i < 4; i++)
            chk(sr[i] == (!sv[i] || r), "R7 in_ready rule", int'(sr[i]), int'(!sv[i] || r));
        for (int i = 0; i < 4; i++) begin
            if (sv[i] && r) begin
                int e;
                string tag;
                e = q_pop(i);
                if (e < 0) begin
                    chk(1'b0, "R7 output beat with no accepted input", 1, 0);
                end else begin
                    if ((e >> 9) & 1)       tag = "R5 first beat of block";
                    else if ((e >> 10) & 1) tag = "R10 beat after idle gap";
                    else if (i == 3)        tag = "R3 recursive parity";
                    else if (i == 1)        tag = "R4 rate 1/3 word";
                    else                    tag = "R2 feed-forward parity";
                    chk(sd[i] == (e & 255), tag, sd[i], e & 255);
                    chk(int'(sl[i]) == ((e >> 8) & 1), "R6 last flag", int'(sl[i]), (e >> 8) & 1);
                end
            end
        end
        acc = sr[0];
        gap = !prev_acc && !first_blk;
        if (v && acc) begin
            for (int i = 0; i < 4; i++) begin
                int w;
                w = ref_word(i, d, mst[i]);
                q_push(i, w | (int'(l) << 8) | (int'(first_blk) << 9) | (int'(gap) << 10));
                if (l) mst[i] = 0;
            end
            first_blk = l;
        end
        prev_acc = v && acc;
        prev_stall = sv[0] && !r;
        prev_beat = sd[0] | (int'(sl[0]) << 8);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nfail++;
        $display("FAIL R7 watchdog expired actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        bit acc;
        // R1: reset state
        repeat (4) begin
            @(negedge clk);
            sample_outputs();
            chk(!(sv[0] || sv[1] || sv[2] || sv[3]), "R1 out_valid during reset", int'(sv[0]), 0);
        end
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        sample_outputs();
        chk(!sv[0] && !sv[3], "R1 out_valid after reset", int'(sv[0]), 0);
        chk(sr[0] && sr[3], "R1 in_ready after reset", int'(sr[0]), 1);

        // Every 8-bit sequence as its own block, full rate
        for (int blk = 0; blk < 256; blk++)
            for (int i = 0; i < 8; i++)
                cycle(1'b1, blk[7 - i], i == 7, 1'b1, acc);

        // Random bits, random block ends, input gaps and output stalls
        for (int n = 0; n < 3000; n++) begin
            bit d, l, vv;
            d = 1'($urandom % 2);
            l = (($urandom % 8) == 0);
            vv = 1'b0;
            do begin
                if (!vv) vv = (($urandom % 4) != 0);
                cycle(vv, d, l, (($urandom % 3) != 0), acc);
            end while (!(vv && acc));
        end

        // Long stall with input pending, then release
        repeat (12) cycle(1'b1, 1'b1, 1'b0, 1'b0, acc);
        repeat (3) cycle(1'b1, 1'b0, 1'b0, 1'b1, acc);
        cycle(1'b1, 1'b1, 1'b1, 1'b1, acc);
        repeat (6) cycle(1'b0, 1'b0, 1'b0, 1'b1, acc);

        chk(q0.size() == 0 && q1.size() == 0 && q2.size() == 0 && q3.size() == 0,
            "R7 all accepted beats delivered", q0.size() + q3.size(), 0);
        chk(!ov0 && !ov3, "R7 stage empty after drain", int'(ov0), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end
endmodule